// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns an instruction-fetch virtual address into a physical address, together with an uncacheable flag and a fault code. It sits in front of a translation buffer and handles every case that needs no stored mapping: privileged-code fetches whose address carries a marker in bit 0, requests flagged as already physical, non-canonical addresses, and a directly mapped kernel window. For every other address it presents the virtual page number and address-space number to the buffer, and it builds the physical address from the frame number and per-mode execute enables the buffer returns.

Every candidate physical address then goes through a range check and a cacheability check. An address with its top implemented bit set is uncacheable and gets a bit field cleared, unless it lies in a register window that this design does not implement, in which case it faults. Results appear one clock after the request. Three counters report hits, misses and access violations.

Top module: `ifx_xlate`

## Requirements
- R1: Outputs are registered: `rsp_valid` equals `req_valid` of the previous cycle, and a cycle without a request yields `rsp_pa`=0, `rsp_uncache`=0, `rsp_fault`=0. Reset clears all outputs and counters.
- R2: When `req_va[0]` is 1, the candidate PA is `req_va` with bits 1:0 cleared and bits 63:44 cleared. No buffer result, physical flag or mode affects it, and it counts as a hit.
- R3: When `req_phys` is 1 (and bit 0 is 0), the candidate PA is `req_va` unchanged.
- R4: When bits 63:47 of the address are not all equal, the fault code is 1 (access violation).
- R5: A canonical address with bits 47:41 equal to 7'h7E is a direct window. In mode 0 the candidate PA is bits 39:0 of the address, with bits 43:40 set to 1111 when bit 40 is 1 and bits 63:40 zero otherwise. In modes 1 to 3 the fault code is 1.
- R6: Other addresses drive `tlb_vpn` = bits 47:13 and `tlb_asn` = `req_asn`. When `tlb_hit` is 0 the fault code is 2 (miss).
- R7: On a hit the candidate PA is `tlb_ppn` shifted left by 13, ORed with address bits 12:2 (bits 1:0 zero). The fault code is 1 when `tlb_xre[req_mode]` is 0. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R8: A candidate PA with any of bits 63:44 set gives fault code 3 (machine check).
- R9: A candidate PA with bit 43 set gives fault code 4 when its bits 39:32 are all ones. Otherwise `rsp_uncache` is 1 and PA bits 42:35 are cleared.
- R10: Checks apply in this order: marker bit, physical flag, canonical form, window mode, miss, permission, range, register window. The first one that fires sets the code. With any fault, `rsp_pa` and `rsp_uncache` are 0.
- R11: `cnt_hit` counts marker-bit requests and permitted buffer hits, `cnt_miss` counts misses, and `cnt_acv` counts code-1 faults. Each counter changes one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Address is already physical |
| req_mode | input | 2 | Current privilege mode |
| req_asn | input | 8 | Current address-space number |
| tlb_vpn | output | 35 | Page number presented to the buffer |
| tlb_asn | output | 8 | Address-space number presented to the buffer |
| tlb_hit | input | 1 | Buffer found a matching entry |
| tlb_ppn | input | 32 | Frame number of the matching entry |
| tlb_xre | input | 4 | Per-mode execute enables of the entry |
| rsp_valid | output | 1 | Result present |
| rsp_pa | output | 44 | Physical address (0 on fault) |
| rsp_uncache | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | 0 none, 1 violation, 2 miss, 3 machine check, 4 unimplemented window |
| cnt_hit | output | 16 | Hit count |
| cnt_miss | output | 16 | Miss count |
| cnt_acv | output | 16 | Access-violation count |

## Verification
The hardest cases to reach are those where two late checks compete on a buffer hit. One is an entry whose frame number lands outside the implemented range while its mode enable is clear. The other is an entry whose frame number lands in the register window or the uncached region. Neither occurs with ordinary addresses. The bench therefore models its own buffer, preloaded with entries whose frame numbers are chosen for these windows and whose enable patterns differ by mode. Random fetches then pick those entries with random modes and with matching or mismatching address-space numbers. Directed cases place window addresses on the sign-extension bit and on the register window.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_MCHK  = 3'd3,
    FLT_UNIMP = 3'd4
  } ifx_fault_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } ifx_mode_e;

  // ones in bits n-1:0
  function automatic logic [63:0] low_ones(input int unsigned n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // marker-bit fetch: drop the two low bits, keep implemented width
  function automatic logic [63:0] marker_addr(input logic [63:0] va, input int unsigned pa_bits);
    return va & ~64'd3 & low_ones(pa_bits);
  endfunction

  // direct window: replicate ext bit upward or truncate below it
  function automatic logic [63:0] window_addr(input logic [63:0] va, input int unsigned pa_bits,
                                              input int unsigned ext);
    logic [63:0] base;
    base = va & low_ones(pa_bits);
    if (base[ext]) return base | (low_ones(pa_bits) & ~low_ones(ext));
    return base & low_ones(ext);
  endfunction

  // mapped page: frame shifted by page size plus word-aligned offset
  function automatic logic [63:0] page_addr(input logic [63:0] frame, input logic [63:0] off,
                                            input int unsigned shift);
    return (frame << shift) | (off & ~64'd3);
  endfunction

  // uncached fixup: clear bits pa_bits-2 .. lo
  function automatic logic [63:0] uc_strip(input logic [63:0] pa, input int unsigned pa_bits,
                                           input int unsigned lo);
    return pa & ~(low_ones(pa_bits - 1) & ~low_ones(lo));
  endfunction

endpackage

// File: rtl/ifx_region.sv
module ifx_region
  import ifx_pkg::*;
#(
  parameter int VA_IMPL    = 48,
  parameter int PA_IMPL    = 44,
  parameter logic [6:0] SP_TAG = 7'h7E,
  parameter int SP_EXT_BIT = 40
) (
  input  logic [63:0] va,
  output logic        is_marker,
  output logic        is_canon,
  output logic        is_window,
  output logic [63:0] marker_pa,
  output logic [63:0] window_pa
);
  localparam int TAG_HI = VA_IMPL - 1;
  localparam int TAG_LO = VA_IMPL - 7;

  always_comb begin
    is_marker = va[0];
    is_canon  = (&va[63:VA_IMPL-1]) | ~(|va[63:VA_IMPL-1]);
    is_window = (va[TAG_HI:TAG_LO] == SP_TAG);
    marker_pa = marker_addr(va, PA_IMPL);
    window_pa = window_addr(va, PA_IMPL, SP_EXT_BIT);
  end
endmodule

// File: rtl/ifx_tlbpath.sv
module ifx_tlbpath
  import ifx_pkg::*;
#(
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int MODE_W     = 2
) (
  input  logic [PAGE_SHIFT-1:0]    off,
  input  logic [MODE_W-1:0]        mode,
  input  logic [PPN_W-1:0]         ppn,
  input  logic [(1<<MODE_W)-1:0]   xre,
  output logic [63:0]              page_pa,
  output logic                     perm_ok
);
  always_comb begin
    page_pa = page_addr({{(64-PPN_W){1'b0}}, ppn}, {{(64-PAGE_SHIFT){1'b0}}, off}, PAGE_SHIFT);
    perm_ok = xre[mode];
  end
endmodule

// File: rtl/ifx_finish.sv
module ifx_finish
  import ifx_pkg::*;
#(
  parameter int PA_IMPL   = 44,
  parameter int UC_CLR_LO = 35,
  parameter int IPR_HI    = 39,
  parameter int IPR_LO    = 32
) (
  input  logic [63:0]        raw,
  output logic               out_of_range,
  output logic               uncached,
  output logic               in_ipr,
  output logic [PA_IMPL-1:0] pa_out
);
  always_comb begin
    out_of_range = |(raw & ~low_ones(PA_IMPL));
    uncached     = raw[PA_IMPL-1];
    in_ipr       = &raw[IPR_HI:IPR_LO];
    pa_out       = PA_IMPL'(uncached ? uc_strip(raw, PA_IMPL, UC_CLR_LO) : raw);
  end
endmodule

// File: rtl/ifx_counters.sv
module ifx_counters #(
  parameter int CNT_W = 16,
  parameter int N     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc,
  output logic [N*CNT_W-1:0]  count
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (!rst_n)      c <= '0;
      else if (inc[g]) c <= c + CNT_W'(1);
    end
    assign count[g*CNT_W +: CNT_W] = c;
  end
endmodule

// File: rtl/ifx_xlate.sv
module ifx_xlate
  import ifx_pkg::*;
#(
  parameter int VA_IMPL     = 48,
  parameter int PA_IMPL     = 44,
  parameter int PAGE_SHIFT  = 13,
  parameter int PPN_W       = 32,
  parameter int ASN_W       = 8,
  parameter int MODE_W      = 2,
  parameter int CNT_W       = 16,
  parameter logic [6:0] SP_TAG = 7'h7E,
  parameter int SP_EXT_BIT  = 40,
  parameter int UC_CLR_LO   = 35,
  parameter int IPR_HI      = 39,
  parameter int IPR_LO      = 32,
  parameter bit EN_COUNTERS = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [63:0]                   req_va,
  input  logic                          req_phys,
  input  logic [MODE_W-1:0]             req_mode,
  input  logic [ASN_W-1:0]              req_asn,
  output logic [VA_IMPL-PAGE_SHIFT-1:0] tlb_vpn,
  output logic [ASN_W-1:0]              tlb_asn,
  input  logic                          tlb_hit,
  input  logic [PPN_W-1:0]              tlb_ppn,
  input  logic [(1<<MODE_W)-1:0]        tlb_xre,
  output logic                          rsp_valid,
  output logic [PA_IMPL-1:0]            rsp_pa,
  output logic                          rsp_uncache,
  output logic [2:0]                    rsp_fault,
  output logic [CNT_W-1:0]              cnt_hit,
  output logic [CNT_W-1:0]              cnt_miss,
  output logic [CNT_W-1:0]              cnt_acv
);
  localparam int N_CNT = 3;

  // region decode
  logic        ev_marker, va_canon, va_window;
  logic [63:0] marker_pa, window_pa;

  ifx_region #(
    .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL), .SP_TAG(SP_TAG), .SP_EXT_BIT(SP_EXT_BIT)
  ) u_region (
    .va(req_va), .is_marker(ev_marker), .is_canon(va_canon), .is_window(va_window),
    .marker_pa(marker_pa), .window_pa(window_pa)
  );

  // buffer request and page path
  assign tlb_vpn = req_va[VA_IMPL-1:PAGE_SHIFT];
  assign tlb_asn = req_asn;

  logic [63:0] page_pa;
  logic        page_perm_ok;

  ifx_tlbpath #(.PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W), .MODE_W(MODE_W)) u_page (
    .off(req_va[PAGE_SHIFT-1:0]), .mode(req_mode), .ppn(tlb_ppn), .xre(tlb_xre),
    .page_pa(page_pa), .perm_ok(page_perm_ok)
  );

  // priority chain up to the candidate address
  logic [63:0] raw_pa;
  ifx_fault_e  early_fault;
  logic        ev_badva, ev_winacc, ev_win_deny, ev_miss, ev_perm_deny, ev_hit, ev_acv;

  always_comb begin
    raw_pa       = '0;
    early_fault  = FLT_NONE;
    ev_badva     = 1'b0;
    ev_winacc    = 1'b0;
    ev_win_deny  = 1'b0;
    ev_miss      = 1'b0;
    ev_perm_deny = 1'b0;
    ev_hit       = 1'b0;
    if (ev_marker) begin
      raw_pa = marker_pa;
      ev_hit = 1'b1;
    end else if (req_phys) begin
      raw_pa = req_va;
    end else if (!va_canon) begin
      ev_badva    = 1'b1;
      early_fault = FLT_ACV;
    end else if (va_window) begin
      ev_winacc = 1'b1;
      if (req_mode != MODE_W'(MODE_KERN)) begin
        ev_win_deny = 1'b1;
        early_fault = FLT_ACV;
      end else begin
        raw_pa = window_pa;
      end
    end else if (!tlb_hit) begin
      ev_miss     = 1'b1;
      early_fault = FLT_MISS;
    end else if (!page_perm_ok) begin
      ev_perm_deny = 1'b1;
      early_fault  = FLT_ACV;
    end else begin
      raw_pa = page_pa;
      ev_hit = 1'b1;
    end
  end

  assign ev_acv = ev_badva | ev_win_deny | ev_perm_deny;

  // range and cacheability
  logic               ev_range, pa_uncached, pa_in_ipr;
  logic [PA_IMPL-1:0] fin_pa;

  ifx_finish #(
    .PA_IMPL(PA_IMPL), .UC_CLR_LO(UC_CLR_LO), .IPR_HI(IPR_HI), .IPR_LO(IPR_LO)
  ) u_finish (
    .raw(raw_pa), .out_of_range(ev_range), .uncached(pa_uncached), .in_ipr(pa_in_ipr),
    .pa_out(fin_pa)
  );

  ifx_fault_e         nxt_fault;
  logic [PA_IMPL-1:0] nxt_pa;
  logic               nxt_uc;

  always_comb begin
    nxt_fault = early_fault;
    nxt_pa    = '0;
    nxt_uc    = 1'b0;
    if (early_fault == FLT_NONE) begin
      if (ev_range) begin
        nxt_fault = FLT_MCHK;
      end else if (pa_uncached && pa_in_ipr) begin
        nxt_fault = FLT_UNIMP;
      end else begin
        nxt_pa = fin_pa;
        nxt_uc = pa_uncached;
      end
    end
  end

  // output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      rsp_fault   <= FLT_NONE;
    end else begin
      rsp_valid   <= req_valid;
      rsp_pa      <= req_valid ? nxt_pa : '0;
      rsp_uncache <= req_valid & nxt_uc;
      rsp_fault   <= req_valid ? nxt_fault : FLT_NONE;
    end
  end

  // event counters
  if (EN_COUNTERS) begin : g_counters
    logic [N_CNT*CNT_W-1:0] cnt_bus;
    ifx_counters #(.CNT_W(CNT_W), .N(N_CNT)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc({req_valid & ev_acv, req_valid & ev_miss, req_valid & ev_hit}),
      .count(cnt_bus)
    );
    assign cnt_hit  = cnt_bus[0*CNT_W +: CNT_W];
    assign cnt_miss = cnt_bus[1*CNT_W +: CNT_W];
    assign cnt_acv  = cnt_bus[2*CNT_W +: CNT_W];
  end else begin : g_no_counters
    assign cnt_hit  = '0;
    assign cnt_miss = '0;
    assign cnt_acv  = '0;
  end
endmodule

// File: rtl/ifx_xlate_chk.sv
module ifx_xlate_chk #(
  parameter int PA_IMPL     = 44,
  parameter int UC_CLR_LO   = 35,
  parameter int MODE_W      = 2,
  parameter int CNT_W       = 16,
  parameter bit EN_COUNTERS = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [MODE_W-1:0]  req_mode,
  input logic               ev_marker,
  input logic               ev_badva,
  input logic               ev_winacc,
  input logic               ev_miss,
  input logic               rsp_valid,
  input logic [PA_IMPL-1:0] rsp_pa,
  input logic               rsp_uncache,
  input logic [2:0]         rsp_fault,
  input logic [CNT_W-1:0]   cnt_miss
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_pa == '0));
  p_marker_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_marker) |=> (rsp_pa[1:0] == 2'b00 && rsp_fault != 3'd1 && rsp_fault != 3'd2));
  p_badva_acv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_badva) |=> rsp_fault == 3'd1);
  p_window_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_winacc && req_mode != '0) |=> rsp_fault == 3'd1);
  p_miss_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_miss) |=> rsp_fault == 3'd2);
  p_uc_strip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> (rsp_pa[PA_IMPL-1] && rsp_pa[PA_IMPL-2:UC_CLR_LO] == '0));
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncache));

  if (EN_COUNTERS) begin : g_cnt_chk
    p_miss_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ev_miss) |=> cnt_miss == CNT_W'($past(cnt_miss) + CNT_W'(1)));
  end
endmodule

bind ifx_xlate ifx_xlate_chk #(
  .PA_IMPL(PA_IMPL), .UC_CLR_LO(UC_CLR_LO), .MODE_W(MODE_W), .CNT_W(CNT_W),
  .EN_COUNTERS(EN_COUNTERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .ev_marker(ev_marker), .ev_badva(ev_badva), .ev_winacc(ev_winacc), .ev_miss(ev_miss),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache), .rsp_fault(rsp_fault),
  .cnt_miss(cnt_miss)
);

// File: tb/ifx_xlate_test.sv
`timescale 1ns/1ps
module ifx_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_phys = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [7:0]  req_asn = '0;
  logic [34:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_xre;
  logic        rsp_valid;
  logic [43:0] rsp_pa;
  logic        rsp_uncache;
  logic [2:0]  rsp_fault;
  logic [15:0] cnt_hit, cnt_miss, cnt_acv;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int e_hit = 0, e_miss = 0, e_acv = 0;

  always #4 clk = ~clk;

  ifx_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_phys(req_phys),
    .req_mode(req_mode), .req_asn(req_asn), .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache), .rsp_fault(rsp_fault),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_acv(cnt_acv)
  );

  // bench-owned buffer
  logic [34:0] t_vpn [8];
  logic [7:0]  t_asn [8];
  logic [31:0] t_ppn [8];
  logic [3:0]  t_xre [8];

  initial begin
    for (int i = 0; i < 8; i++) begin
      t_vpn[i] = 35'h100 + 35'(i * 3);
      t_asn[i] = 8'(i);
      t_ppn[i] = 32'h0000_0200 + 32'(i * 17);
      t_xre[i] = 4'((i * 7 + 5) & 15);
    end
    t_ppn[5] = 32'h4000_1234;  // uncached, outside register window
    t_ppn[6] = 32'h47F8_0000;  // uncached, register window
    t_ppn[7] = 32'h8000_0001;  // beyond implemented range
  end

  always_comb begin
    tlb_hit = 1'b0; tlb_ppn = '0; tlb_xre = '0;
    for (int i = 0; i < 8; i++)
      if (t_vpn[i] == tlb_vpn && t_asn[i] == tlb_asn) begin
        tlb_hit = 1'b1; tlb_ppn = t_ppn[i]; tlb_xre = t_xre[i];
      end
  end

  function automatic void expect_of(input logic [63:0] va, input logic phys, input logic [1:0] mode,
                                    input logic [7:0] asn, output logic [43:0] pa, output logic uc,
                                    output logic [2:0] f, output int dh, output int dm,
                                    output int da, output string tag);
    logic [63:0] p;
    int idx;
    p = '0; f = 3'd0; uc = 1'b0; dh = 0; dm = 0; da = 0; idx = -1;
    if (va[0]) begin
      p = {20'd0, va[43:2], 2'b00}; dh = 1; tag = "R2";
    end else if (phys) begin
      p = va; tag = "R3";
    end else if (va[63:47] != 17'd0 && va[63:47] != 17'h1FFFF) begin
      f = 3'd1; da = 1; tag = "R4";
    end else if (va[47:41] == 7'h7E) begin
      tag = "R5";
      if (mode != 2'd0) begin f = 3'd1; da = 1; end
      else if (va[40]) p = {20'd0, 4'hF, va[39:0]};
      else p = {24'd0, va[39:0]};
    end else begin
      for (int i = 0; i < 8; i++) if (t_vpn[i] == va[47:13] && t_asn[i] == asn) idx = i;
      if (idx < 0) begin f = 3'd2; dm = 1; tag = "R6"; end
      else if (!t_xre[idx][mode]) begin f = 3'd1; da = 1; tag = "R7"; end
      else begin
        p = ({32'd0, t_ppn[idx]} * 64'd8192) + {51'd0, va[12:2], 2'b00};
        dh = 1; tag = "R7";
      end
    end
    if (f == 3'd0) begin
      if (p[63:44] != 20'd0) begin f = 3'd3; tag = "R8"; end
      else if (p[43] && p[39:32] == 8'hFF) begin f = 3'd4; tag = "R9"; end
      else if (p[43]) begin uc = 1'b1; p[42:35] = 8'd0; tag = "R9"; end
    end
    pa = (f == 3'd0) ? p[43:0] : 44'd0;
  endfunction

  task automatic check(input string tag, input string note, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, note, act, exp);
    end
  endtask

  // call at a negedge; returns at the next negedge with the result checked
  task automatic xact(input logic [63:0] va, input logic phys, input logic [1:0] mode,
                      input logic [7:0] asn, input string note);
    logic [43:0] pa; logic uc; logic [2:0] f; int dh, dm, da; string tag;
    expect_of(va, phys, mode, asn, pa, uc, f, dh, dm, da, tag);
    req_valid = 1'b1; req_va = va; req_phys = phys; req_mode = mode; req_asn = asn;
    #1;
    if (!va[0] && !phys) check("R6", {note, " lookup vpn"}, {29'd0, tlb_vpn}, {29'd0, va[47:13]});
    @(negedge clk);
    e_hit += dh; e_miss += dm; e_acv += da;
    check(tag, {note, " result"}, {16'd0, rsp_valid, rsp_uncache, rsp_fault, rsp_pa},
          {16'd0, 1'b1, uc, f, pa});
    check("R11", {note, " counters"}, {16'd0, cnt_hit, cnt_miss, cnt_acv},
          {16'd0, 16'(e_hit), 16'(e_miss), 16'(e_acv)});
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] entry_va(input int i, input logic [12:0] off);
    return {17'd0, t_vpn[i], off[12:1], 1'b0};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset outputs", {16'd0, rsp_valid, rsp_uncache, rsp_fault, rsp_pa}, 64'd0);
    check("R1", "reset counters", {16'd0, cnt_hit, cnt_miss, cnt_acv}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    xact(64'hFFFF_0000_1234_5677, 1'b1, 2'd3, 8'd0, "marker plain");
    xact(64'h0000_08FF_0000_0001, 1'b0, 2'd0, 8'd0, "marker in register window");
    xact(64'h0000_0000_0012_3450, 1'b1, 2'd2, 8'd0, "physical plain");
    xact(64'h0004_0000_0000_0000, 1'b1, 2'd0, 8'd0, "physical out of range");
    xact(64'h0000_0812_3456_7890, 1'b1, 2'd0, 8'd0, "physical uncached");
    xact(64'h0001_0000_0000_0000, 1'b0, 2'd0, 8'd0, "non-canonical");
    xact(64'h0001_0000_0000_0000, 1'b1, 2'd0, 8'd0, "R10 physical before canonical");
    xact(64'hFFFF_FC00_1234_5678, 1'b0, 2'd0, 8'd0, "window low");
    xact(64'hFFFF_FD12_3456_7898, 1'b0, 2'd0, 8'd0, "window sign extended");
    xact(64'hFFFF_FC00_1234_5678, 1'b0, 2'd3, 8'd0, "window user mode");
    xact(64'hFFFF_FDFF_0000_0000, 1'b0, 2'd0, 8'd0, "R10 window into register window");
    xact(entry_va(2, 13'h1ABC), 1'b0, 2'd0, 8'd9, "miss on asn");
    xact(entry_va(0, 13'h0FFE), 1'b0, 2'd0, 8'd0, "hit kernel");
    xact(entry_va(0, 13'h0FFE), 1'b0, 2'd1, 8'd0, "hit exec denied");
    xact(entry_va(7, 13'h0010), 1'b0, 2'd0, 8'd7, "R10 permission before range");
    xact(entry_va(7, 13'h0010), 1'b0, 2'd1, 8'd7, "hit out of range");
    xact(entry_va(6, 13'h0020), 1'b0, 2'd0, 8'd6, "hit register window");
    xact(entry_va(5, 13'h1FFC), 1'b0, 2'd3, 8'd5, "hit uncached");
    // R1: idle cycle clears outputs
    @(negedge clk);
    check("R1", "idle outputs", {16'd0, rsp_valid, rsp_uncache, rsp_fault, rsp_pa}, 64'd0);

    for (int n = 0; n < 600; n++) begin
      logic [63:0] va; logic phys; int k, e;
      va = {$urandom, $urandom};
      phys = 1'b0;
      k = int'($urandom % 6);
      e = int'($urandom % 8);
      case (k)
        0: va[0] = 1'b1;
        1: begin va[0] = 1'b0; phys = 1'b1; if ($urandom % 2 == 0) va[63:44] = '0; end
        2: begin va[0] = 1'b0; va[63:47] = 17'h0AAAA; end
        3: va = {17'h1FFFF, 7'h7E, va[39:1], 1'b0};
        4: va = entry_va(e, va[12:0]);
        default: va = {17'd0, 7'h11, va[39:1], 1'b0};
      endcase
      xact(va, phys, 2'($urandom), (k == 4 && $urandom % 4 != 0) ? t_asn[e] : 8'($urandom),
           "random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule